// File: doc/BRIEF.md
# Filtered Two-Wire Configuration Register Target

This block is a target on a two-wire serial bus that opens a small configuration register bank to an external host. It runs entirely from a fast local reference clock. The clock and data lines are oversampled, synchronised and put through a persistence filter. Bus conditions, bit strobes and the nine-clock byte frame are then decoded from the filtered copies. The target answers to a 7-bit address set on strap pins, so up to 128 such targets can share one bus.

A write transfer carries a register index in its first data byte. Each later byte goes to the indexed register, and the index then advances. A read transfer returns bytes from the current index onward, and the index advances after each byte is fetched. The data line is driven low through an output enable. The register bank sits outside the block and is reached through a plain write strobe and a combinational read address and data pair.

Top module: `cfgbus_target`

## Requirements
- R1: While reset is held, and on the first cycle after it, `sda_oe` is 0 and `reg_we` is 0.
- R2: Bus activity before the first START is ignored. A full address byte clocked without a START gets no acknowledge.
- R3: After a START the target shifts in 7 address bits MSB first, then a direction bit (1 = read, 0 = write). When the address equals `strap_addr`, it pulls SDA low for the whole ninth clock.
- R4: On an address mismatch the target does not acknowledge and keeps SDA released. It acknowledges no further byte and writes no register until the next START.
- R5: In a write transfer the first data byte sets the register index to its low `$clog2(NREGS)` bits. Each later byte gives one single-cycle `reg_we` pulse at the current index and then increments the index modulo NREGS. Every data byte is acknowledged.
- R6: In a read transfer the target sends the register at the current index MSB first and increments the index after each byte it fetches, wrapping modulo NREGS.
- R7: When the host does not acknowledge a read byte (SDA high in the ninth clock), the target releases SDA until the next START.
- R8: A repeated START with no STOP ends the current transfer and begins a new address phase. The register index is kept.
- R9: A STOP ends the transfer at any point. A partly received data byte is discarded and the index is kept.
- R10: A pulse on SCL lasting fewer than FILT reference clocks has no effect on the transfer.
- R11: The target changes `sda_oe` only while the filtered SCL is low, a few clocks after its falling edge. Write data is sampled on the filtered rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_addr | input | 7 | Bus address of this target |
| reg_we | output | 1 | Register write strobe, one cycle |
| reg_waddr | output | AW | Register write index |
| reg_wdata | output | 8 | Register write data |
| reg_raddr | output | AW | Register read index (current index) |
| reg_rdata | input | 8 | Register read data for `reg_raddr` |

## Verification
The bench clocks a full address byte with no START before it. A target that reacts to framing alone would acknowledge it. It sends a wrong address followed by a data byte; a target that falls back into the byte engine would acknowledge or write. It aborts a data byte half-way with a STOP and then reads from the kept index, which exposes both a stray write and a lost index. Index values near NREGS-1 for reads and writes catch a failure to wrap. A two-clock SCL spike inserted inside a data byte would shift an extra bit into a target with a weak filter. Throughout the run the output enable is compared every cycle against a model of when it should change.

// File: rtl/cfgbus_pkg.sv
`timescale 1ns/1ps
package cfgbus_pkg;
  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;
  localparam int NLINES   = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK
  } tgt_state_e;
endpackage

// File: rtl/cfgbus_line_filter.sv
`timescale 1ns/1ps
module cfgbus_line_filter #(
  parameter int FILT = 3,
  localparam int CW = $clog2(FILT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic q
);
  logic [1:0]    sync_q;
  logic          samp;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          q_d;

  assign samp = sync_q[1];

  always_comb begin
    cnt_d = '0;
    q_d   = q;
    if (samp != q) begin
      if (cnt_q == CW'(FILT - 1)) begin
        q_d = samp;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      q      <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw};
      cnt_q  <= cnt_d;
      q      <= q_d;
    end
  end

  generate
    if (FILT >= 2) begin : g_chk
      p_filt_persist_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q) |-> (($past(samp) == q) && ($past(samp, 2) == q)));
    end
  endgenerate
endmodule

// File: rtl/cfgbus_cond_detect.sv
`timescale 1ns/1ps
module cfgbus_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise  = !scl_p && scl_f;
  assign scl_fall  = scl_p && !scl_f;
  assign start_det = scl_p && scl_f && sda_p && !sda_f;
  assign stop_det  = scl_p && scl_f && !sda_p && sda_f;
endmodule

// File: rtl/cfgbus_engine.sv
`timescale 1ns/1ps
module cfgbus_engine
  import cfgbus_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [6:0]    strap,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [AW-1:0] rd_addr
);
  tgt_state_e    st_q, st_d;
  logic [2:0]    cnt_q, cnt_d;
  logic [7:0]    sh_q, sh_d;
  logic          rw_q, rw_d;
  logic          first_q, first_d;
  logic          done_q, done_d;
  logic          ack_q, ack_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          oe_q, oe_d;
  logic          we_q, we_d;
  logic [AW-1:0] wa_q, wa_d;
  logic [7:0]    wd_q, wd_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rw_d    = rw_q;
    first_d = first_q;
    done_d  = done_q;
    ack_d   = ack_q;
    ptr_d   = ptr_q;
    oe_d    = oe_q;
    we_d    = 1'b0;
    wa_d    = wa_q;
    wd_d    = wd_q;
    if (start_det) begin
      st_d   = ST_ADDR;
      cnt_d  = '0;
      done_d = 1'b0;
      oe_d   = 1'b0;
    end else if (stop_det) begin
      st_d   = ST_IDLE;
      done_d = 1'b0;
      oe_d   = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: ;
        ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_lvl};
            cnt_d = cnt_q + 3'd1;
            if (cnt_q == 3'd7) done_d = 1'b1;
          end else if (scl_fall && done_q) begin
            done_d = 1'b0;
            if (st_q == ST_ADDR) begin
              if (sh_q[7:1] == strap) begin
                rw_d = sh_q[0];
                oe_d = 1'b1;
                st_d = ST_AACK;
              end else begin
                st_d = ST_IDLE;
              end
            end else begin
              oe_d = 1'b1;
              st_d = ST_WACK;
              if (first_q) begin
                ptr_d   = sh_q[AW-1:0];
                first_d = 1'b0;
              end else begin
                we_d  = 1'b1;
                wa_d  = ptr_q;
                wd_d  = sh_q;
                ptr_d = ptr_q + AW'(1);
              end
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              sh_d  = rd_data;
              ptr_d = ptr_q + AW'(1);
              oe_d  = ~rd_data[7];
              st_d  = ST_RD;
            end else begin
              oe_d    = 1'b0;
              first_d = 1'b1;
              st_d    = ST_WR;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            oe_d  = 1'b0;
            cnt_d = '0;
            st_d  = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt_q == 3'd7) begin
              oe_d = 1'b0;
              st_d = ST_RACK;
            end else begin
              cnt_d = cnt_q + 3'd1;
              sh_d  = {sh_q[6:0], 1'b0};
              oe_d  = ~sh_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            ack_d = ~sda_lvl;
          end else if (scl_fall) begin
            cnt_d = '0;
            if (ack_q) begin
              sh_d  = rd_data;
              ptr_d = ptr_q + AW'(1);
              oe_d  = ~rd_data[7];
              st_d  = ST_RD;
            end else begin
              oe_d = 1'b0;
              st_d = ST_IDLE;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
      ack_q   <= 1'b0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      wa_q    <= '0;
      wd_q    <= '0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rw_q    <= rw_d;
      first_q <= first_d;
      done_q  <= done_d;
      ack_q   <= ack_d;
      ptr_q   <= ptr_d;
      oe_q    <= oe_d;
      we_q    <= we_d;
      wa_q    <= wa_d;
      wd_q    <= wd_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_en   = we_q;
  assign wr_addr = wa_q;
  assign wr_data = wd_q;
  assign rd_addr = ptr_q;

  p_idle_release_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !sda_oe);
  p_we_single_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  p_ack_match_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_AACK) |-> (sh_q[7:1] == strap));
  p_start_addr_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st_q == ST_ADDR));
  p_stop_idle_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> ((st_q == ST_IDLE) && !sda_oe));
  p_oe_scl_low_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl);
endmodule

// File: rtl/cfgbus_target.sv
`timescale 1ns/1ps
module cfgbus_target
  import cfgbus_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int FILT  = 3,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [6:0]    strap_addr,
  output logic          reg_we,
  output logic [AW-1:0] reg_waddr,
  output logic [7:0]    reg_wdata,
  output logic [AW-1:0] reg_raddr,
  input  logic [7:0]    reg_rdata
);
  logic [1:0]        rst_sync;
  logic              rst_i;
  logic [NLINES-1:0] raw_vec, filt_vec;
  logic              scl_rise, scl_fall, start_det, stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  assign raw_vec[LINE_SCL] = scl_i;
  assign raw_vec[LINE_SDA] = sda_i;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    cfgbus_line_filter #(.FILT(FILT)) u_filt (
      .clk  (clk),
      .rst_n(rst_i),
      .raw  (raw_vec[g]),
      .q    (filt_vec[g])
    );
  end

  cfgbus_cond_detect u_cond (
    .clk      (clk),
    .rst_n    (rst_i),
    .scl_f    (filt_vec[LINE_SCL]),
    .sda_f    (filt_vec[LINE_SDA]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  cfgbus_engine #(.AW(AW)) u_eng (
    .clk      (clk),
    .rst_n    (rst_i),
    .scl_lvl  (filt_vec[LINE_SCL]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_lvl  (filt_vec[LINE_SDA]),
    .start_det(start_det),
    .stop_det (stop_det),
    .strap    (strap_addr),
    .rd_data  (reg_rdata),
    .sda_oe   (sda_oe),
    .wr_en    (reg_we),
    .wr_addr  (reg_waddr),
    .wr_data  (reg_wdata),
    .rd_addr  (reg_raddr)
  );
endmodule

// File: tb/cfgbus_target_test.sv
`timescale 1ns/1ps
module cfgbus_target_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREGS = 8;
  localparam int AW = 3;
  localparam int Q = 16;
  localparam logic [6:0] STRAP = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1;
  logic sda_host = 1'b1;
  logic sda_oe, reg_we;
  logic [AW-1:0] reg_waddr, reg_raddr;
  logic [7:0] reg_wdata, reg_rdata;
  logic sda_bus;

  logic [7:0] mem [NREGS];
  logic [7:0] ref_mem [NREGS];
  logic [AW+7:0] wq [$];
  logic [AW-1:0] ref_ptr = '0;
  logic exp_oe = 1'b0;
  logic glitch_en = 1'b0;
  int cyc = 0;
  int settle_until = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  assign sda_bus = sda_host & ~sda_oe;
  assign reg_rdata = mem[reg_raddr];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgbus_target #(.NREGS(NREGS), .FILT(3)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_bus),
    .sda_oe(sda_oe), .strap_addr(STRAP), .reg_we(reg_we),
    .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (reg_we) mem[reg_waddr] <= reg_wdata;
  end

  // Reference comparison of the data-line enable on every clock (R11, R7, R4)
  always @(negedge clk) begin
    if (rst_n && cyc >= settle_until)
      chk(sda_oe == exp_oe, "R11 sda_oe vs model", int'(sda_oe), int'(exp_oe));
  end

  // Register writes must match the queue of expected writes (R5, R9, R10)
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (wq.size() == 0) begin
        chk(1'b0, "R5 unexpected reg_we", int'(reg_waddr), -1);
      end else begin
        logic [AW+7:0] e;
        e = wq.pop_front();
        chk({reg_waddr, reg_wdata} == e, "R5 write addr/data", int'({reg_waddr, reg_wdata}), int'(e));
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic scl_set(input logic v);
    scl_drv = v;
    settle_until = cyc + 12;
  endtask

  task automatic sda_set(input logic v);
    sda_host = v;
    settle_until = cyc + 12;
  endtask

  task automatic clk_bit(input logic b, output logic s);
    wt(Q);
    sda_set(b);
    if (glitch_en) begin
      wt(4);
      scl_set(1'b1);
      wt(2);
      scl_set(1'b0);
      wt(Q - 6);
    end else begin
      wt(Q);
    end
    scl_set(1'b1);
    wt(Q);
    s = sda_bus;
    wt(Q);
    scl_set(1'b0);
  endtask

  task automatic start_c();
    sda_set(1'b1);
    wt(Q);
    scl_set(1'b1);
    wt(Q);
    sda_set(1'b0);
    wt(Q);
    scl_set(1'b0);
    exp_oe = 1'b0;
  endtask

  task automatic stop_c();
    wt(Q);
    sda_set(1'b0);
    wt(Q);
    scl_set(1'b1);
    wt(Q);
    sda_set(1'b1);
    wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    exp_oe = exp_ack;
    clk_bit(1'b1, s);
    acked = !s;
    exp_oe = 1'b0;
  endtask

  task automatic addr(input logic rw, input string tag);
    bit a;
    send_byte({STRAP, rw}, 1'b1, a);
    chk(a, tag, int'(a), 1);
    if (rw) exp_oe = ~ref_mem[ref_ptr][7];
  endtask

  task automatic wbyte(input logic [7:0] b, input bit first, input string tag);
    bit a;
    if (first) begin
      ref_ptr = b[AW-1:0];
    end else begin
      wq.push_back({ref_ptr, b});
      ref_mem[ref_ptr] = b;
      ref_ptr = ref_ptr + AW'(1);
    end
    send_byte(b, 1'b1, a);
    chk(a, tag, int'(a), 1);
  endtask

  task automatic rbyte(input bit ack, input string tag);
    logic s;
    logic [7:0] d, e;
    e = ref_mem[ref_ptr];
    ref_ptr = ref_ptr + AW'(1);
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
      exp_oe = (i > 0) ? ~e[i-1] : 1'b0;
    end
    clk_bit(!ack, s);
    exp_oe = ack ? ~ref_mem[ref_ptr][7] : 1'b0;
    chk(d == e, tag, int'(d), int'(e));
  endtask

  initial begin
    bit a;
    logic s;
    for (int i = 0; i < NREGS; i++) begin
      mem[i] = 8'h00;
      ref_mem[i] = 8'h00;
    end
    wt(6);
    rst_n = 1'b1;
    wt(1);
    chk(sda_oe == 1'b0 && reg_we == 1'b0, "R1 reset outputs", int'({sda_oe, reg_we}), 0);
    wt(10);

    // R2: address byte without a START
    scl_set(1'b0);
    send_byte({STRAP, 1'b0}, 1'b0, a);
    chk(!a, "R2 no ack before START", int'(a), 0);
    stop_c();

    // R3/R5: write two registers from index 2
    start_c();
    addr(1'b0, "R3 address ack");
    wbyte(8'h02, 1'b1, "R5 index byte ack");
    wbyte(8'hA5, 1'b0, "R5 data ack");
    wbyte(8'h3C, 1'b0, "R5 data ack");
    stop_c();

    // R8/R6/R7: set index, repeated START, read two bytes, NACK the last
    start_c();
    addr(1'b0, "R3 address ack");
    wbyte(8'h02, 1'b1, "R5 index byte ack");
    start_c();
    addr(1'b1, "R8 read after repeated START");
    rbyte(1'b1, "R6 read byte 0");
    rbyte(1'b0, "R6 read byte 1");
    wt(Q);
    chk(sda_oe == 1'b0, "R7 released after NACK", int'(sda_oe), 0);
    stop_c();

    // R4: wrong address, then a data byte
    start_c();
    send_byte({STRAP ^ 7'h01, 1'b0}, 1'b0, a);
    chk(!a, "R4 no ack on mismatch", int'(a), 0);
    send_byte(8'h55, 1'b0, a);
    chk(!a, "R4 no ack after mismatch", int'(a), 0);
    stop_c();

    // R5: index truncation and wrap on write
    start_c();
    addr(1'b0, "R3 address ack");
    wbyte(8'h0F, 1'b1, "R5 index byte ack");
    wbyte(8'h11, 1'b0, "R5 wrap data ack");
    wbyte(8'h22, 1'b0, "R5 wrap data ack");
    stop_c();

    // R10: SCL spikes inside a data byte
    start_c();
    addr(1'b0, "R3 address ack");
    wbyte(8'h03, 1'b1, "R10 index byte ack");
    glitch_en = 1'b1;
    wbyte(8'h96, 1'b0, "R10 data ack with spikes");
    glitch_en = 1'b0;
    stop_c();

    // R9: STOP in the middle of a data byte
    start_c();
    addr(1'b0, "R3 address ack");
    wbyte(8'h05, 1'b1, "R9 index byte ack");
    for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
    stop_c();

    // R9/R6: read from kept index, wrap on read
    start_c();
    addr(1'b1, "R9 read after abort");
    rbyte(1'b1, "R9 index kept byte 5");
    rbyte(1'b1, "R6 read byte 6");
    rbyte(1'b1, "R6 read byte 7");
    rbyte(1'b0, "R6 read wrap byte 0");
    stop_c();

    // R10: read back the byte written under spikes
    start_c();
    addr(1'b0, "R3 address ack");
    wbyte(8'h03, 1'b1, "R5 index byte ack");
    start_c();
    addr(1'b1, "R8 read after repeated START");
    rbyte(1'b0, "R10 spiked byte read back");
    stop_c();

    wt(20);
    chk(wq.size() == 0, "R9 all expected writes seen", wq.size(), 0);
    for (int i = 0; i < NREGS; i++)
      chk(mem[i] == ref_mem[i], "R5 register contents", int'(mem[i]), int'(ref_mem[i]));

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule